// File: doc/BRIEF.md
# Three-Lane PRBS7 Pattern Source and Error Checker

This block sits in front of three serial lanes and can replace their normal bit streams with a test pattern. A 2-bit mode input selects one of four sources: the normal lane data, a PRBS7 sequence, a slow square wave, or a fast square wave. One rule limits mode changes. A direct move from the fast toggle to the slow toggle is refused, so software must step through normal mode between the two.

On the receive side, each lane has a checker. When counting is enabled, the checker fills its own 7-bit shift register from the first seven received bits. From then on it predicts every further bit and flags each bit that does not match the prediction. Mismatches accumulate in a saturating 8-bit counter for that lane. A register bus outside this block reads the counter. The bus signals each read with a one-cycle strobe, and the counter clears once that read is over.

The lanes carry one bit per clock with no handshake. They cannot be stalled, so there is no back-pressure. The mode, enable and strobe inputs are plain level or pulse controls.

Top module: `prt_lane_tester`

## Requirements
- R1: With mode 0 (normal), or after reset, each `tx_data_o` bit equals the matching `norm_data_i` bit in the same cycle.
- R2: An accepted mode change takes effect at the next rising clock edge. After that edge the new pattern starts from its first bit, and it advances by one bit per clock.
- R3: Mode 3 (fast toggle) drives 1, 0, 1, 0, ... on all lanes, starting with 1.
- R4: Mode 2 (slow toggle) drives five 0s then five 1s, repeating, on all lanes.
- R5: Mode 1 drives PRBS7 on all lanes. The generator uses x^7+x^6+1 and starts from all ones. The output bit is state bit 6, and each step shifts left and inserts bit6 XOR bit5 at bit 0. The state is never all zeros.
- R6: When the active mode is 3 and mode 2 is requested, the request is ignored. The fast toggle continues without restarting.
- R7: Counting is enabled while `cnt_en_i` is high. From the rise of `cnt_en_i`, a lane checker loads its first 7 received bits as its state. It then counts one error for each received bit that differs from bit6 XOR bit5 of its state, and shifts the predicted bit in. While `cnt_en_i` is low, no errors are counted, and the checker synchronizes again on the next enable.
- R8: Each lane's 8-bit counter holds at 255 (0xFF) when more errors arrive.
- R9: While `rd_clr_i[l]` is high, `err_cnt_o` lane l still shows the old value, and after that edge it reads 0. If an error arrives in the same cycle as the read, the counter reads 1 afterwards.
- R10: After reset, all counters read 0 and the active mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Requested source: 0 normal, 1 PRBS7, 2 slow toggle, 3 fast toggle |
| cnt_en_i | input | 1 | Error counting enable |
| norm_data_i | input | LANES | Normal lane bits, one per lane |
| tx_data_o | output | LANES | Outgoing lane bits |
| rx_data_i | input | LANES | Received lane bits to check |
| rd_clr_i | input | LANES | Read strobe per lane, clears that counter after the cycle |
| err_cnt_o | output | LANES*8 | Error counters, lane l at bits [8l+7:8l] |

## Verification
The assertions check the following on every cycle:
- The fast-to-slow refusal holds.
- The PRBS state never reaches zero.
- The fast toggle alternates.
- A counter never falls except after a read, holds at its maximum, and sits at 0 or 1 after a read.

Only the bench scenarios can show the rest: the exact bit sequences of each pattern and their restart on a mode change, the seven-bit synchronization, and counts that match injected bit flips. The same goes for a read that coincides with an error, and for the resynchronization after counting is switched off and on again.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_PRBS = 2'd1,
    MODE_LO   = 2'd2,
    MODE_HI   = 2'd3
  } mode_e;

  localparam int PRBS_ORDER = 7;
  localparam int PRBS_TAP_A = 6;
  localparam int PRBS_TAP_B = 5;
  localparam logic [PRBS_ORDER-1:0] PRBS_SEED = {PRBS_ORDER{1'b1}};

  function automatic logic [PRBS_ORDER-1:0] prbs_step(input logic [PRBS_ORDER-1:0] s);
    return {s[PRBS_ORDER-2:0], s[PRBS_TAP_A] ^ s[PRBS_TAP_B]};
  endfunction
endpackage

// File: rtl/prt_pattern_gen.sv
module prt_pattern_gen
  import prt_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int LO_HALF = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [LANES-1:0] norm_data_i,
  output logic [LANES-1:0] tx_data_o
);
  localparam int LO_PERIOD = 2 * LO_HALF;
  localparam int LO_W      = $clog2(LO_PERIOD);

  mode_e                 cur_mode;
  mode_e                 nxt_mode;
  logic                  mode_change;
  logic [PRBS_ORDER-1:0] lfsr;
  logic [LO_W-1:0]       lo_cnt;
  logic                  hi_bit;
  logic                  pat_bit;

  // Mode acceptance: the fast-to-slow step is refused and the current mode kept.
  always_comb begin
    nxt_mode = mode_e'(mode_i);
    if (cur_mode == MODE_HI && mode_e'(mode_i) == MODE_LO)
      nxt_mode = cur_mode;
    mode_change = (nxt_mode != cur_mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= MODE_NORM;
      lfsr     <= PRBS_SEED;
      lo_cnt   <= '0;
      hi_bit   <= 1'b1;
    end else begin
      cur_mode <= nxt_mode;
      if (mode_change) begin
        lfsr   <= PRBS_SEED;
        lo_cnt <= '0;
        hi_bit <= 1'b1;
      end else begin
        lfsr   <= prbs_step(lfsr);
        lo_cnt <= (lo_cnt == LO_W'(LO_PERIOD - 1)) ? '0 : lo_cnt + 1'b1;
        hi_bit <= ~hi_bit;
      end
    end
  end

  always_comb begin
    unique case (cur_mode)
      MODE_PRBS: pat_bit = lfsr[PRBS_ORDER-1];
      MODE_LO:   pat_bit = (lo_cnt >= LO_W'(LO_HALF));
      MODE_HI:   pat_bit = hi_bit;
      default:   pat_bit = 1'b0;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_mux
    assign tx_data_o[l] = (cur_mode == MODE_NORM) ? norm_data_i[l] : pat_bit;
  end

  // R6: a fast-to-slow request leaves the fast toggle in place
  p_hi_to_lo_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_HI && mode_i == 2'd2) |=> (cur_mode == MODE_HI));

  // R5: the generator state never reaches zero
  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R3: staying in fast toggle flips the output every cycle
  p_hi_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_mode) == MODE_HI && cur_mode == MODE_HI) |-> (pat_bit != $past(pat_bit)));
endmodule

// File: rtl/prt_lane_checker.sv
module prt_lane_checker
  import prt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rx_i,
  output logic err_o
);
  localparam int SC_W = $clog2(PRBS_ORDER);

  logic [PRBS_ORDER-1:0] state;
  logic [SC_W-1:0]       load_cnt;
  logic                  locked;
  logic                  pred;

  assign pred  = state[PRBS_TAP_A] ^ state[PRBS_TAP_B];
  assign err_o = en_i & locked & (rx_i != pred);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= '0;
      load_cnt <= '0;
      locked   <= 1'b0;
    end else if (!en_i) begin
      load_cnt <= '0;
      locked   <= 1'b0;
    end else if (!locked) begin
      state <= {state[PRBS_ORDER-2:0], rx_i};
      if (load_cnt == SC_W'(PRBS_ORDER - 1)) begin
        locked <= 1'b1;
      end else begin
        load_cnt <= load_cnt + 1'b1;
      end
    end else begin
      state <= {state[PRBS_ORDER-2:0], pred};
    end
  end

  // R7: nothing is flagged in the cycle counting has just been enabled
  p_no_err_on_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> !err_o);
endmodule

// File: rtl/prt_err_counter.sv
module prt_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (rd_clr_i) begin
      cnt_o <= {{(CNT_W-1){1'b0}}, err_i};
    end else if (err_i && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R8: a full counter stays full until read
  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !rd_clr_i) |=> (cnt_o == CNT_MAX));

  // R9: after a read only the coinciding error can remain
  p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (cnt_o <= CNT_W'(1)));

  // R8: without a read the count never goes down
  p_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/prt_lane_tester.sv
module prt_lane_tester
  import prt_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int CNT_W   = 8,
  parameter int LO_HALF = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_i,
  input  logic                   cnt_en_i,
  input  logic [LANES-1:0]       norm_data_i,
  output logic [LANES-1:0]       tx_data_o,
  input  logic [LANES-1:0]       rx_data_i,
  input  logic [LANES-1:0]       rd_clr_i,
  output logic [LANES*CNT_W-1:0] err_cnt_o
);
  logic [LANES-1:0] lane_err;

  prt_pattern_gen #(
    .LANES  (LANES),
    .LO_HALF(LO_HALF)
  ) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .norm_data_i(norm_data_i),
    .tx_data_o  (tx_data_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    prt_lane_checker u_chk (
      .clk  (clk),
      .rst_n(rst_n),
      .en_i (cnt_en_i),
      .rx_i (rx_data_i[l]),
      .err_o(lane_err[l])
    );

    prt_err_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_i   (lane_err[l]),
      .rd_clr_i(rd_clr_i[l]),
      .cnt_o   (err_cnt_o[l*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/prt_lane_tester_bench.sv
`timescale 1ns/1ps
module prt_lane_tester_bench;
  localparam int LANES = 3;
  localparam int CW    = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode_i;
  logic             cnt_en_i;
  logic [LANES-1:0] norm_data_i;
  logic [LANES-1:0] tx_data_o;
  logic [LANES-1:0] rx_data_i;
  logic [LANES-1:0] rd_clr_i;
  logic [LANES-1:0] flip;
  logic [LANES*CW-1:0] err_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit    is_cnt;
    int    lane;
    int    exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  assign rx_data_i = tx_data_o ^ flip;

  prt_lane_tester u_prt_lane_tester (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cnt_en_i(cnt_en_i),
    .norm_data_i(norm_data_i), .tx_data_o(tx_data_o), .rx_data_i(rx_data_i),
    .rd_clr_i(rd_clr_i), .err_cnt_o(err_cnt_o)
  );

  // Monitor: compares every queued expectation just after the falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      act = it.is_cnt ? int'(err_cnt_o[it.lane*CW +: CW]) : int'(tx_data_o);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s lane=%0d actual=%0d expected=%0d", it.tag, it.lane, act, it.exp);
      end
    end
  end

  function automatic int pat_bit(int m, int k);
    logic [6:0] s;
    case (m)
      1: begin
        s = 7'h7F;
        for (int i = 0; i < k; i++) s = {s[5:0], s[6] ^ s[5]};
        return int'(s[6]);
      end
      2: return ((k % 10) >= 5) ? 1 : 0;
      3: return ((k % 2) == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic push_tx(int exp, string tag);
    item_t it;
    it.is_cnt = 0; it.lane = 0; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic push_cnt(int lane, int exp, string tag);
    item_t it;
    it.is_cnt = 1; it.lane = lane; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_pat(int m, int start, int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push_tx(pat_bit(m, start + i) ? 7 : 0, tag);
    end
  endtask

  task automatic rd(int lane, int exp, string tag);
    rd_clr_i[lane] = 1'b1;
    push_cnt(lane, exp, tag);
    @(negedge clk);
    rd_clr_i = '0;
  endtask

  task automatic flip_lane(int lane, int n);
    flip[lane] = 1'b1;
    repeat (n) @(negedge clk);
    flip[lane] = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_i = 2'd0; cnt_en_i = 0; norm_data_i = 3'b101;
    rd_clr_i = '0; flip = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 / R1: reset state
    push_tx(5, "R10 normal after reset");
    for (int l = 0; l < LANES; l++) push_cnt(l, 0, "R10 counter zero");
    @(negedge clk);
    norm_data_i = 3'b010;
    push_tx(2, "R1 passthrough");
    // R3 / R2: fast toggle from first bit
    mode_i = 2'd3;
    expect_pat(3, 0, 6, "R3 fast toggle");
    // R6: fast to slow refused, toggle continues
    mode_i = 2'd2;
    expect_pat(3, 6, 6, "R6 refused change");
    // R1: back through normal
    mode_i = 2'd0; norm_data_i = 3'b110;
    @(negedge clk);
    push_tx(6, "R1 normal again");
    // R4: slow toggle
    mode_i = 2'd2;
    expect_pat(2, 0, 12, "R4 slow toggle");
    // R2: slow to fast is allowed and restarts
    mode_i = 2'd3;
    expect_pat(3, 0, 4, "R2 restart on change");
    // R5: PRBS7
    mode_i = 2'd1;
    expect_pat(1, 0, 20, "R5 prbs7");
    // R7: sync then clean counting
    cnt_en_i = 1;
    repeat (12) @(negedge clk);
    for (int l = 0; l < LANES; l++) rd(l, 0, "R7 clean link");
    flip_lane(1, 1);
    flip_lane(0, 3);
    repeat (2) @(negedge clk);
    rd(0, 3, "R7 three flips");
    rd(1, 1, "R7 one flip");
    rd(2, 0, "R7 untouched lane");
    rd(0, 0, "R9 cleared by read");
    // R8: saturation
    flip_lane(2, 300);
    @(negedge clk);
    rd(2, 255, "R8 saturated");
    rd(2, 0, "R9 clear after saturation");
    // R9: read and error together
    flip_lane(2, 2);
    flip[2] = 1'b1; rd_clr_i[2] = 1'b1;
    push_cnt(2, 2, "R9 old value during read");
    @(negedge clk);
    flip = '0; rd_clr_i = '0;
    rd(2, 1, "R9 error on read cycle");
    // R7: disabled counting ignores flips
    cnt_en_i = 0;
    flip_lane(0, 5);
    rd(0, 0, "R7 disabled no count");
    cnt_en_i = 1;
    repeat (10) @(negedge clk);
    rd(0, 0, "R7 resync clean");
    flip_lane(0, 1);
    @(negedge clk);
    rd(0, 1, "R7 count after resync");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule